// File: doc/BRIEF.md
# Eight-Task Run-to-Completion Dispatcher

This block sequences work for a small coprocessor that holds up to eight tasks. A task is requested either by a peripheral trigger line or by a software request that the host writes through a small register port. Each request that reaches an enabled task sets that task's pending flag. Whenever the coprocessor is idle, the dispatcher picks the pending task with the highest fixed priority. It loads that task's 12-bit start address from the task's vector register into the program counter output, and it issues a one-cycle start pulse.

A running task is never interrupted. The dispatcher waits for the end-of-task strobe from the engine and then pulses the completion interrupt belonging to that task. One cycle later it launches the next pending task without any host action. The host writes the vectors, the enable mask and software requests, and it reads back the vectors, the enable mask, the pending flags and the run status. Tasks 1 to 8 map to bits 0 to 7 of every per-task mask and to index values 0 to 7.

Top module: `task_sched`

## Requirements
- R1: A synchronous active-high reset clears all pending flags, the enable mask, the busy flag, the start pulse, the interrupt outputs, the program counter output and all eight vector registers to zero.
- R2: A peripheral trigger bit that is high at a clock edge, or a host write of a one to bit i of register address 9, sets pending bit i at that edge only if enable bit i is set. A trigger on a disabled task sets nothing.
- R3: When the block is idle and some flag is pending, the next edge dispatches a task. It loads that task's vector into `pc_out`, raises `start_pulse` for exactly one cycle, sets `busy`, sets `run_idx` to the task index and clears that task's pending bit at the same edge.
- R4: Priority is fixed. The lowest pending index (task 1, index 0) wins over all higher indices.
- R5: While `busy` is high and no end-of-task strobe is seen, no new start happens, and `run_idx` and `pc_out` hold their values, whatever triggers arrive.
- R6: An end-of-task strobe while busy clears `busy` at that edge and raises only bit `run_idx` of `task_irq` for exactly one cycle. A strobe while idle has no effect.
- R7: After a completion, the next pending task is dispatched at the edge after the strobe edge, so the interrupt cycle never carries a start. Successive tasks run in priority order.
- R8: A trigger on a task that is already pending is absorbed. Any number of repeats before dispatch gives exactly one run.
- R9: A trigger on the task that is running sets its pending flag again, so the task runs once more after it completes.
- R10: Register map: addresses 0 to 7 hold the vectors of tasks 1 to 8, read back as 12 bits with the upper bits zero. Address 8 is the enable mask (bits 7:0). Address 9 is write-only software request and reads zero. Address 10 reads the pending flags. Address 11 reads `{busy, run_idx}` in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_trig | input | 8 | Peripheral trigger lines, one per task, sampled each edge |
| task_done | input | 1 | End-of-task strobe from the engine |
| reg_wr | input | 1 | Host write enable |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from `reg_addr` |
| pc_out | output | 12 | Program counter loaded at dispatch |
| start_pulse | output | 1 | One-cycle pulse at dispatch |
| busy | output | 1 | A task is running |
| run_idx | output | 3 | Index of the running or last run task |
| task_irq | output | 8 | Per-task completion pulses |

## Verification
A trigger or software-request write lands in the pending flags at the very next edge, so the pending readback is sampled one cycle after the stimulus. A dispatch lands one edge later, two edges after the trigger when idle, so the start pulse, `pc_out` and `run_idx` are checked there. The completion interrupt and the fall of `busy` are due at the strobe edge, and the follow-on start comes one edge after that. The bench drives inputs and samples outputs on the falling clock edge and steps whole cycles between them, so every check lands in exactly the cycle counted above. The table walk replays each trigger pattern and follows the whole drain order through successive completions.

// File: rtl/task_sched_pkg.sv
package task_sched_pkg;

    // default geometry
    localparam int TS_NTASK  = 8;
    localparam int TS_PC_W   = 12;
    localparam int TS_DATA_W = 16;
    localparam int TS_ADDR_W = 4;

    // host register addresses above the vector window
    localparam int TS_A_ENABLE = 8;
    localparam int TS_A_SWREQ  = 9;
    localparam int TS_A_PEND   = 10;
    localparam int TS_A_STATUS = 11;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/task_prio.sv
module task_prio
    import task_sched_pkg::*;
#(
    parameter int N_TASK = TS_NTASK,
    localparam int IDX_W = idx_width(N_TASK)
) (
    input  logic [N_TASK-1:0] req,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);

    // ripple chain: lowest set index wins
    logic [N_TASK:0]  seen;
    logic [IDX_W-1:0] cand [N_TASK+1];

    assign seen[0] = 1'b0;
    assign cand[0] = '0;

    for (genvar g = 0; g < N_TASK; g++) begin : g_chain
        assign seen[g+1] = seen[g] | req[g];
        assign cand[g+1] = (req[g] && !seen[g]) ? IDX_W'(g) : cand[g];
    end

    assign any = seen[N_TASK];
    assign idx = cand[N_TASK];

endmodule

// File: rtl/task_pend.sv
module task_pend
    import task_sched_pkg::*;
#(
    parameter int N_TASK = TS_NTASK,
    localparam int IDX_W = idx_width(N_TASK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TASK-1:0] set_mask,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic [N_TASK-1:0] pend
);

    logic [N_TASK-1:0] clr_mask;

    for (genvar g = 0; g < N_TASK; g++) begin : g_clr
        assign clr_mask[g] = clr_en && (clr_idx == IDX_W'(g));
    end

    // a set on the same edge as the clear wins: re-arms a dispatched task
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_mask) | set_mask;
        end
    end

endmodule

// File: rtl/task_regs.sv
module task_regs
    import task_sched_pkg::*;
#(
    parameter int N_TASK = TS_NTASK,
    parameter int PC_W   = TS_PC_W,
    parameter int DATA_W = TS_DATA_W,
    parameter int ADDR_W = TS_ADDR_W,
    localparam int IDX_W = idx_width(N_TASK)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [N_TASK-1:0]      pend,
    input  logic                   busy,
    input  logic [IDX_W-1:0]       run_idx,
    output logic [N_TASK*PC_W-1:0] vec_flat,
    output logic [N_TASK-1:0]      en_mask,
    output logic [N_TASK-1:0]      sw_req,
    output logic [DATA_W-1:0]      rdata
);

    logic [PC_W-1:0] vec_q [N_TASK];

    for (genvar g = 0; g < N_TASK; g++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst) begin
                vec_q[g] <= '0;
            end else if (wr && addr == ADDR_W'(g)) begin
                vec_q[g] <= wdata[PC_W-1:0];
            end
        end
        assign vec_flat[g*PC_W +: PC_W] = vec_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_mask <= '0;
        end else if (wr && addr == ADDR_W'(TS_A_ENABLE)) begin
            en_mask <= wdata[N_TASK-1:0];
        end
    end

    assign sw_req = (wr && addr == ADDR_W'(TS_A_SWREQ)) ? wdata[N_TASK-1:0] : '0;

    always_comb begin
        rdata = '0;
        if (addr < ADDR_W'(N_TASK)) begin
            rdata = DATA_W'(vec_q[addr[IDX_W-1:0]]);
        end else if (addr == ADDR_W'(TS_A_ENABLE)) begin
            rdata = DATA_W'(en_mask);
        end else if (addr == ADDR_W'(TS_A_PEND)) begin
            rdata = DATA_W'(pend);
        end else if (addr == ADDR_W'(TS_A_STATUS)) begin
            rdata = DATA_W'({busy, run_idx});
        end
    end

endmodule

// File: rtl/task_seq.sv
module task_seq
    import task_sched_pkg::*;
#(
    parameter int N_TASK = TS_NTASK,
    parameter int PC_W   = TS_PC_W,
    localparam int IDX_W = idx_width(N_TASK)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pick_any,
    input  logic [IDX_W-1:0]       pick_idx,
    input  logic [N_TASK*PC_W-1:0] vec_flat,
    input  logic                   done,
    output logic                   launch,
    output logic                   busy,
    output logic [IDX_W-1:0]       run_idx,
    output logic [PC_W-1:0]        pc,
    output logic                   start,
    output logic [N_TASK-1:0]      irq
);

    seq_state_e state;

    // launch only from idle; the idle cycle after a completion gives the gap
    assign launch = (state == SEQ_IDLE) && pick_any;
    assign busy   = (state == SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            run_idx <= '0;
            pc      <= '0;
            start   <= 1'b0;
            irq     <= '0;
        end else begin
            start <= 1'b0;
            irq   <= '0;
            case (state)
                SEQ_IDLE: begin
                    if (pick_any) begin
                        state   <= SEQ_RUN;
                        run_idx <= pick_idx;
                        pc      <= vec_flat[pick_idx*PC_W +: PC_W];
                        start   <= 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (done) begin
                        state <= SEQ_IDLE;
                        irq   <= N_TASK'(1) << run_idx;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/task_sched.sv
module task_sched
    import task_sched_pkg::*;
#(
    parameter int N_TASK = TS_NTASK,
    parameter int PC_W   = TS_PC_W,
    parameter int DATA_W = TS_DATA_W,
    parameter int ADDR_W = TS_ADDR_W,
    localparam int IDX_W = idx_width(N_TASK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TASK-1:0] hw_trig,
    input  logic              task_done,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [PC_W-1:0]   pc_out,
    output logic              start_pulse,
    output logic              busy,
    output logic [IDX_W-1:0]  run_idx,
    output logic [N_TASK-1:0] task_irq
);

    logic [N_TASK*PC_W-1:0] vec_flat;
    logic [N_TASK-1:0]      en_mask;
    logic [N_TASK-1:0]      sw_req;
    logic [N_TASK-1:0]      pend;
    logic [N_TASK-1:0]      arm;
    logic                   pick_any;
    logic [IDX_W-1:0]       pick_idx;
    logic                   launch;

    assign arm = (hw_trig | sw_req) & en_mask;

    task_regs #(
        .N_TASK(N_TASK), .PC_W(PC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .pend     (pend),
        .busy     (busy),
        .run_idx  (run_idx),
        .vec_flat (vec_flat),
        .en_mask  (en_mask),
        .sw_req   (sw_req),
        .rdata    (reg_rdata)
    );

    task_pend #(.N_TASK(N_TASK)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_mask (arm),
        .clr_en   (launch),
        .clr_idx  (pick_idx),
        .pend     (pend)
    );

    task_prio #(.N_TASK(N_TASK)) u_prio (
        .req (pend),
        .any (pick_any),
        .idx (pick_idx)
    );

    task_seq #(.N_TASK(N_TASK), .PC_W(PC_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .vec_flat (vec_flat),
        .done     (task_done),
        .launch   (launch),
        .busy     (busy),
        .run_idx  (run_idx),
        .pc       (pc_out),
        .start    (start_pulse),
        .irq      (task_irq)
    );

endmodule

// File: rtl/task_sched_chk.sv
module task_sched_chk #(
    parameter int N_TASK = 8,
    parameter int PC_W   = 12,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              task_done,
    input logic [PC_W-1:0]   pc_out,
    input logic              start_pulse,
    input logic              busy,
    input logic [IDX_W-1:0]  run_idx,
    input logic [N_TASK-1:0] task_irq
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !start_pulse && task_irq == '0));

    assert_start_from_idle_R3: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (busy && !$past(busy)));

    assert_no_preempt_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !task_done) |=> (busy && !start_pulse && $stable(run_idx) && $stable(pc_out)));

    assert_irq_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(task_irq));

    assert_done_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && task_done) |=> (!busy && task_irq == (N_TASK'(1) << $past(run_idx))));

    assert_gap_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        (task_irq != '0) |-> (!busy && !start_pulse));

endmodule

bind task_sched task_sched_chk #(
    .N_TASK(N_TASK), .PC_W(PC_W), .IDX_W(IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .task_done   (task_done),
    .pc_out      (pc_out),
    .start_pulse (start_pulse),
    .busy        (busy),
    .run_idx     (run_idx),
    .task_irq    (task_irq)
);

// File: tb/test_task_sched.sv
module test_task_sched;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NT         = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  hw_trig = '0;
    logic        task_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [11:0] pc_out;
    logic        start_pulse;
    logic        busy;
    logic [2:0]  run_idx;
    logic [7:0]  task_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    task_sched i_task_sched (
        .clk(clk), .rst(rst), .hw_trig(hw_trig), .task_done(task_done),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pc_out(pc_out), .start_pulse(start_pulse),
        .busy(busy), .run_idx(run_idx), .task_irq(task_irq)
    );

    // {enable, trigger, expected first task number (0 = none)}
    localparam logic [19:0] TBL [10] = '{
        {8'hFF, 8'h01, 4'd1},
        {8'hFF, 8'h80, 4'd8},
        {8'hFF, 8'hA4, 4'd3},
        {8'hFF, 8'hFF, 4'd1},
        {8'h0F, 8'hF0, 4'd0},
        {8'hF0, 8'h3C, 4'd5},
        {8'h55, 8'hAA, 4'd0},
        {8'hAA, 8'hFE, 4'd2},
        {8'h81, 8'h81, 4'd1},
        {8'h7E, 8'h81, 4'd0}
    };

    function automatic logic [11:0] vexp(input int i);
        return 12'(32'h0A0 + i * 32'h111);
    endfunction

    function automatic int lowest(input logic [7:0] m);
        for (int k = 0; k < NT; k++) if (m[k]) return k;
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_one(input int idx, input string req);
        task_done = 1'b1;
        step();
        task_done = 1'b0;
        check({req, " irq"}, 32'(task_irq), 32'(8'(1) << idx));
        check({req, " busy low"}, 32'(busy), 0);
        check({req, " no start in irq cycle"}, 32'(start_pulse), 0);
        step();
    endtask

    task automatic write_vectors();
        for (int i = 0; i < NT; i++) wr(4'(i), 16'(vexp(i)) | 16'hF000);
    endtask

    logic [15:0] rv;

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        check("watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        step();
        rst = 1'b0;

        // R1: reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 start", 32'(start_pulse), 0);
        check("R1 irq", 32'(task_irq), 0);
        check("R1 pc", 32'(pc_out), 0);
        rd(4'd10, rv); check("R1 pending", 32'(rv), 0);
        rd(4'd8, rv);  check("R1 enable", 32'(rv), 0);
        rd(4'd3, rv);  check("R1 vector", 32'(rv), 0);

        // R10: register map, 12-bit vectors
        write_vectors();
        rd(4'd7, rv); check("R10 vector7 width", 32'(rv), 32'(vexp(7)));
        rd(4'd0, rv); check("R10 vector0", 32'(rv), 32'(vexp(0)));
        wr(4'd9, 16'h0000);
        rd(4'd9, rv); check("R10 swreq reads zero", 32'(rv), 0);

        // table walk: R2 R3 R4 R7
        for (int t = 0; t < 10; t++) begin
            logic [7:0] en, tg, rem;
            int first, guard;
            en = TBL[t][19:12]; tg = TBL[t][11:4]; first = int'(TBL[t][3:0]);
            wr(4'd8, 16'(en));
            rd(4'd8, rv); check("R10 enable readback", 32'(rv), 32'(en));
            hw_trig = tg;
            step();
            hw_trig = '0;
            rem = tg & en;
            rd(4'd10, rv); check("R2 pending after trigger", 32'(rv), 32'(rem));
            check("R3 no start yet", 32'(start_pulse), 0);
            step();
            if (first != 0) begin
                check("R3 start pulse", 32'(start_pulse), 1);
                check("R4 winner", 32'(run_idx), 32'(first - 1));
                check("R3 pc", 32'(pc_out), 32'(vexp(first - 1)));
                rd(4'd10, rv); check("R3 pending cleared", 32'(rv), 32'(rem & ~(8'(1) << (first - 1))));
            end else begin
                check("R2 disabled stays idle", 32'(busy), 0);
            end
            guard = 0;
            while (busy && guard < 12) begin
                int e;
                e = lowest(rem);
                check("R7 order", 32'(run_idx), 32'(e));
                check("R7 pc", 32'(pc_out), 32'(vexp(e)));
                rem[e] = 1'b0;
                finish_one(e, "R6");
                guard++;
            end
            check("R7 all drained", 32'(rem), 0);
        end

        // R5: no preemption, then R7 follow-on
        wr(4'd8, 16'h00FF);
        hw_trig = 8'h10; step(); hw_trig = '0; step();
        check("R5 running task5", 32'(run_idx), 4);
        hw_trig = 8'h01; step(); hw_trig = '0;
        for (int c = 0; c < 4; c++) begin
            check("R5 no start", 32'(start_pulse), 0);
            check("R5 idx held", 32'(run_idx), 4);
            check("R5 pc held", 32'(pc_out), 32'(vexp(4)));
            step();
        end
        rd(4'd10, rv); check("R5 task1 waits pending", 32'(rv), 32'h01);
        finish_one(4, "R6 task5");
        check("R7 follow-on start", 32'(start_pulse), 1);
        check("R7 follow-on idx", 32'(run_idx), 0);
        finish_one(0, "R6 task1");

        // R8: repeats on a pending task are absorbed; sw request (R2)
        wr(4'd9, 16'h0004);
        rd(4'd10, rv); check("R2 sw request pending", 32'(rv), 32'h04);
        step();
        check("R2 sw dispatch idx", 32'(run_idx), 2);
        hw_trig = 8'h20; step(); step(); step(); hw_trig = '0;
        rd(4'd10, rv); check("R8 single pending", 32'(rv), 32'h20);
        finish_one(2, "R6 task3");
        check("R8 task6 start", 32'(run_idx), 5);
        finish_one(5, "R8 task6");
        check("R8 ran once", 32'(busy), 0);
        rd(4'd10, rv); check("R8 nothing left", 32'(rv), 0);

        // R9: retrigger of running task
        hw_trig = 8'h02; step(); hw_trig = '0; step();
        check("R9 task2 running", 32'(run_idx), 1);
        rd(4'd11, rv); check("R10 status", 32'(rv), 32'h9);
        hw_trig = 8'h02; step(); hw_trig = '0;
        rd(4'd10, rv); check("R9 re-pended", 32'(rv), 32'h02);
        finish_one(1, "R9 first run");
        check("R9 second start", 32'(start_pulse), 1);
        check("R9 second idx", 32'(run_idx), 1);
        finish_one(1, "R9 second run");
        check("R9 done", 32'(busy), 0);

        // R2: disabled triggers ignored, both sources
        wr(4'd8, 16'h000F);
        hw_trig = 8'h40; step(); hw_trig = '0;
        wr(4'd9, 16'h0080);
        rd(4'd10, rv); check("R2 disabled ignored", 32'(rv), 0);
        step();
        check("R2 disabled no run", 32'(busy), 0);

        // R6: strobe while idle has no effect
        task_done = 1'b1; step(); task_done = 1'b0;
        check("R6 idle strobe irq", 32'(task_irq), 0);
        check("R6 idle strobe busy", 32'(busy), 0);

        // R1: reset mid-run clears state
        wr(4'd8, 16'h00FF);
        hw_trig = 8'h48; step(); hw_trig = '0; step();
        check("R1 pre-reset busy", 32'(busy), 1);
        rst = 1'b1; step(); rst = 1'b0;
        check("R1 busy cleared", 32'(busy), 0);
        rd(4'd10, rv); check("R1 pending cleared", 32'(rv), 0);
        rd(4'd8, rv);  check("R1 enable cleared", 32'(rv), 0);
        rd(4'd6, rv);  check("R1 vector cleared", 32'(rv), 0);
        step();
        check("R1 no dispatch after reset", 32'(start_pulse), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule